// File: doc/BRIEF.md
# Multiprocessor-Capable Asynchronous Serial Transceiver

This block is a full-duplex asynchronous serial port for a host that reads and writes data through simple strobed registers. Each frame on the line is a low start bit, then 7 or 8 data bits with the least significant bit first, then an optional extra bit, then a high stop bit. A free-running divider produces a 16x oversampling tick. The receiver samples each bit at its centre, and the transmitter changes the line on tick boundaries.

In normal mode the extra bit is an optional even or odd parity bit. In multiprocessor mode the data length is always 8 bits and the extra bit carries an address/data flag instead of parity. A transmit holding register with an empty flag and a receive data register with a full flag let the host stay one frame ahead. Level interrupt outputs follow those flags through per-direction enables. The receiver reports a framing error, a parity error and an overrun.

Top module: `mp_uart`

## Requirements
- R1: After reset, `txd` is high, `tx_empty` is 1, `rx_full` is 0, and all three error flags are 0.
- R2: A transmitted frame is a 0 start bit, the data bits LSB first, an optional extra bit and a 1 stop bit. Each bit lasts 16*DIV clock cycles. The frame has 2 + data length + (1 if an extra bit is present) bits. The receiver recovers the same data from such a frame.
- R3: In normal mode with `cfg_len8`=0, exactly 7 data bits are sent and received, and bit 7 of `rx_rdata` reads 0.
- R4: In normal mode with `cfg_par_en`=1, the extra bit is the XOR of the data bits when `cfg_par_odd`=0, and its inverse when `cfg_par_odd`=1. A received extra bit that differs from this value sets `err_parity`.
- R5: When `cfg_mp`=1, 8 data bits are used whatever `cfg_len8` is, and `cfg_par_en` has no effect. The extra bit is the `tx_wad` value captured with the data. On receive, the extra bit appears on `rx_ad` and never sets `err_parity`.
- R6: A `tx_wr` pulse while `tx_empty`=1 stores the data and clears `tx_empty`. A `tx_wr` while `tx_empty`=0 is ignored. `tx_empty` returns to 1 in the same cycle that `txd` drops for the start bit of the stored data.
- R7: While `tx_enable`=0, no new frame starts: a stored byte stays held, `txd` stays high and `tx_empty` stays 0.
- R8: While `rx_enable`=0, the receiver ignores the line and `rx_full` never rises.
- R9: A completed frame loads `rx_rdata` and sets `rx_full`. An `rx_rd` pulse clears `rx_full` and all error flags.
- R10: A stop bit sampled low sets `err_frame`.
- R11: A frame that completes while `rx_full` is set (and not read in that cycle) sets `err_overrun` and leaves `rx_rdata` unchanged.
- R12: A low level on the line that is no longer present at the centre of the start bit is dropped as a false start and produces no frame.
- R13: `tx_irq` equals `tx_irq_en` AND `tx_empty`. `rx_irq` equals `rx_irq_en` AND `rx_full`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rxd | input | 1 | Serial receive line (asynchronous) |
| txd | output | 1 | Serial transmit line |
| cfg_mp | input | 1 | 1 selects multiprocessor mode |
| cfg_len8 | input | 1 | Normal mode: 1 for 8 data bits, 0 for 7 |
| cfg_par_en | input | 1 | Normal mode: add a parity bit |
| cfg_par_odd | input | 1 | 1 selects odd parity, 0 selects even |
| tx_enable | input | 1 | Allows new transmit frames to start |
| rx_enable | input | 1 | Allows frame reception |
| tx_irq_en | input | 1 | Transmit interrupt enable |
| rx_irq_en | input | 1 | Receive interrupt enable |
| tx_wr | input | 1 | Write strobe for the transmit holding register |
| tx_wdata | input | 8 | Transmit data |
| tx_wad | input | 1 | Address/data flag sent with the data in multiprocessor mode |
| tx_empty | output | 1 | Transmit holding register can accept data |
| rx_rd | input | 1 | Read strobe for the receive data register |
| rx_rdata | output | 8 | Received data |
| rx_ad | output | 1 | Received address/data flag |
| rx_full | output | 1 | Receive data register holds unread data |
| err_frame | output | 1 | Framing error |
| err_parity | output | 1 | Parity error |
| err_overrun | output | 1 | Overrun error |
| tx_irq | output | 1 | Transmit interrupt |
| rx_irq | output | 1 | Receive interrupt |

## Verification
The assertions assume that the mode and length inputs stay fixed while a frame is in flight. They also assume that the strobes are single-cycle pulses sampled on the clock. The stimulus changes configuration only when both directions are idle. It drives the receive line in whole bit periods of 16*DIV cycles from the bench clock, so every sample point falls well inside a bit. The one exception is a deliberately short low pulse used as a false start. In the framing-error frame, the stop bit is held low only past its centre, so the line is high again before the receiver could confirm a new start bit.

// File: rtl/mp_uart_pkg.sv
package mp_uart_pkg;
    localparam int OVS     = 16;
    localparam int FRAME_W = 11;

    typedef enum logic [1:0] {RX_IDLE, RX_START, RX_DATA} rx_state_e;
    typedef enum logic       {TX_IDLE, TX_BUSY} tx_state_e;

    function automatic logic [3:0] data_len(input logic mp, input logic len8);
        return (mp || len8) ? 4'd8 : 4'd7;
    endfunction

    function automatic logic has_extra(input logic mp, input logic par_en);
        return mp || par_en;
    endfunction

    function automatic logic par_bit(input logic [7:0] d, input logic [3:0] dl, input logic odd);
        logic p;
        p = (dl == 4'd8) ? ^d : ^d[6:0];
        return p ^ odd;
    endfunction
endpackage

// File: rtl/mp_uart_baud.sv
module mp_uart_baud #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          tick;
    } baud_t;

    baud_t q, d;

    always_comb begin
        d = q;
        if (q.cnt == CW'(DIV - 1)) begin
            d.cnt  = '0;
            d.tick = 1'b1;
        end else begin
            d.cnt  = q.cnt + 1'b1;
            d.tick = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign tick = q.tick;
endmodule

// File: rtl/mp_uart_tx.sv
module mp_uart_tx
    import mp_uart_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       mp,
    input  logic       len8,
    input  logic       par_en,
    input  logic       par_odd,
    input  logic       enable,
    input  logic       wr,
    input  logic [7:0] wdata,
    input  logic       wad,
    output logic       empty,
    output logic       txd
);
    localparam int SW = $clog2(OVS);

    typedef struct packed {
        tx_state_e          st;
        logic [7:0]         hold;
        logic               hold_ad;
        logic               empty;
        logic [FRAME_W-1:0] shf;
        logic [3:0]         left;
        logic [SW-1:0]      sub;
    } tx_t;

    tx_t q, d;
    logic [FRAME_W-1:0] frame;
    logic [3:0]         dl;
    logic [3:0]         nb;
    logic               ext;

    always_comb begin
        d     = q;
        dl    = data_len(mp, len8);
        ext   = has_extra(mp, par_en);
        nb    = 4'd2 + dl + {3'b000, ext};
        frame = '1;
        frame[0] = 1'b0;
        for (int i = 0; i < 8; i++) begin
            if (i < int'(dl)) frame[1 + i] = q.hold[i];
        end
        if (ext) frame[4'd1 + dl] = mp ? q.hold_ad : par_bit(q.hold, dl, par_odd);

        if (wr && q.empty) begin
            d.hold    = wdata;
            d.hold_ad = wad;
            d.empty   = 1'b0;
        end

        case (q.st)
            TX_IDLE: begin
                if (tick && enable && !q.empty) begin
                    d.shf   = frame;
                    d.left  = nb;
                    d.sub   = '0;
                    d.empty = 1'b1;
                    d.st    = TX_BUSY;
                end
            end
            default: begin
                if (tick) begin
                    if (q.sub == SW'(OVS - 1)) begin
                        d.sub = '0;
                        if (q.left == 4'd1) begin
                            d.st  = TX_IDLE;
                            d.shf = '1;
                        end else begin
                            d.shf  = {1'b1, q.shf[FRAME_W-1:1]};
                            d.left = q.left - 1'b1;
                        end
                    end else begin
                        d.sub = q.sub + 1'b1;
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q       <= '0;
            q.st    <= TX_IDLE;
            q.empty <= 1'b1;
            q.shf   <= '1;
        end else begin
            q <= d;
        end
    end

    assign empty = q.empty;
    assign txd   = q.shf[0];

    // R6
    empty_rise_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.empty) |-> (txd == 1'b0));
    // R6
    full_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!q.empty && q.st == TX_IDLE && !(tick && enable)) |=> $stable(q.hold));
    // R7
    disabled_no_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!enable && q.st == TX_IDLE) |=> (q.st == TX_IDLE && txd));
endmodule

// File: rtl/mp_uart_rx.sv
module mp_uart_rx
    import mp_uart_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       mp,
    input  logic       len8,
    input  logic       par_en,
    input  logic       par_odd,
    input  logic       enable,
    input  logic       rxd,
    input  logic       rd,
    output logic [7:0] rdata,
    output logic       ad,
    output logic       full,
    output logic       fe,
    output logic       pe,
    output logic       ov
);
    localparam int SW   = $clog2(OVS);
    localparam int SH_W = FRAME_W - 1;

    typedef struct packed {
        logic            s1;
        logic            s2;
        rx_state_e       st;
        logic [SW-1:0]   sub;
        logic [3:0]      cnt;
        logic [SH_W-1:0] sh;
        logic [7:0]      data;
        logic            ad;
        logic            full;
        logic            fe;
        logic            pe;
        logic            ov;
    } rx_t;

    rx_t q, d;
    logic            done;
    logic            full_eff;
    logic [3:0]      dl;
    logic [3:0]      nb;
    logic            ext;
    logic [SH_W-1:0] al;
    logic [7:0]      rx_byte;
    logic            x_bit;
    logic            stop_bit;

    always_comb begin
        d        = q;
        done     = 1'b0;
        dl       = data_len(mp, len8);
        ext      = has_extra(mp, par_en);
        nb       = dl + {3'b000, ext} + 4'd1;
        al       = '0;
        rx_byte  = '0;
        x_bit    = 1'b0;
        stop_bit = 1'b1;
        d.s1     = rxd;
        d.s2     = q.s1;
        full_eff = q.full && !rd;

        if (rd) begin
            d.full = 1'b0;
            d.fe   = 1'b0;
            d.pe   = 1'b0;
            d.ov   = 1'b0;
        end

        if (!enable) begin
            d.st = RX_IDLE;
        end else begin
            case (q.st)
                RX_IDLE: begin
                    if (tick && !q.s2) begin
                        d.st  = RX_START;
                        d.sub = '0;
                    end
                end
                RX_START: begin
                    if (tick) begin
                        if (q.sub == SW'(OVS / 2 - 1)) begin
                            d.st  = q.s2 ? RX_IDLE : RX_DATA;
                            d.sub = '0;
                            d.cnt = '0;
                        end else begin
                            d.sub = q.sub + 1'b1;
                        end
                    end
                end
                default: begin
                    if (tick) begin
                        if (q.sub == SW'(OVS - 1)) begin
                            d.sub = '0;
                            d.sh  = {q.s2, q.sh[SH_W-1:1]};
                            d.cnt = q.cnt + 1'b1;
                            if (q.cnt == nb - 4'd1) begin
                                done = 1'b1;
                                d.st = RX_IDLE;
                            end
                        end else begin
                            d.sub = q.sub + 1'b1;
                        end
                    end
                end
            endcase
        end

        if (done) begin
            al       = d.sh >> (4'd10 - nb);
            rx_byte  = (dl == 4'd8) ? al[7:0] : {1'b0, al[6:0]};
            x_bit    = al[dl];
            stop_bit = al[nb - 4'd1];
            if (full_eff) begin
                d.ov = 1'b1;
            end else begin
                d.data = rx_byte;
                d.full = 1'b1;
                d.fe   = !stop_bit;
                d.pe   = !mp && par_en && (x_bit != par_bit(rx_byte, dl, par_odd));
                d.ad   = mp ? x_bit : 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q    <= '0;
            q.s1 <= 1'b1;
            q.s2 <= 1'b1;
            q.st <= RX_IDLE;
        end else begin
            q <= d;
        end
    end

    assign rdata = q.data;
    assign ad    = q.ad;
    assign full  = q.full;
    assign fe    = q.fe;
    assign pe    = q.pe;
    assign ov    = q.ov;

    // R8
    disabled_no_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> !$rose(q.full));
    // R9
    read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && !done) |=> (!q.full && !q.ov));
    // R11
    held_data_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.full && !rd) |=> $stable(q.data));
    // R5
    mp_no_parity_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mp && $rose(q.full)) |-> !q.pe);
endmodule

// File: rtl/mp_uart.sv
module mp_uart #(
    parameter int DIV = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rxd,
    output logic       txd,
    input  logic       cfg_mp,
    input  logic       cfg_len8,
    input  logic       cfg_par_en,
    input  logic       cfg_par_odd,
    input  logic       tx_enable,
    input  logic       rx_enable,
    input  logic       tx_irq_en,
    input  logic       rx_irq_en,
    input  logic       tx_wr,
    input  logic [7:0] tx_wdata,
    input  logic       tx_wad,
    output logic       tx_empty,
    input  logic       rx_rd,
    output logic [7:0] rx_rdata,
    output logic       rx_ad,
    output logic       rx_full,
    output logic       err_frame,
    output logic       err_parity,
    output logic       err_overrun,
    output logic       tx_irq,
    output logic       rx_irq
);
    logic tick;

    mp_uart_baud #(.DIV(DIV)) u_baud (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick)
    );

    mp_uart_tx u_tx (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .mp      (cfg_mp),
        .len8    (cfg_len8),
        .par_en  (cfg_par_en),
        .par_odd (cfg_par_odd),
        .enable  (tx_enable),
        .wr      (tx_wr),
        .wdata   (tx_wdata),
        .wad     (tx_wad),
        .empty   (tx_empty),
        .txd     (txd)
    );

    mp_uart_rx u_rx (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .mp      (cfg_mp),
        .len8    (cfg_len8),
        .par_en  (cfg_par_en),
        .par_odd (cfg_par_odd),
        .enable  (rx_enable),
        .rxd     (rxd),
        .rd      (rx_rd),
        .rdata   (rx_rdata),
        .ad      (rx_ad),
        .full    (rx_full),
        .fe      (err_frame),
        .pe      (err_parity),
        .ov      (err_overrun)
    );

    assign tx_irq = tx_irq_en && tx_empty;
    assign rx_irq = rx_irq_en && rx_full;

    // R13
    rx_irq_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_irq_en && $rose(rx_full)) |-> rx_irq);
    // R13
    tx_irq_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_irq_en && $fell(tx_empty)) |-> !tx_irq);
endmodule

// File: tb/mp_uart_bench.sv
module mp_uart_bench;
    localparam int DIV  = 4;
    localparam int BITC = 16 * DIV;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic       rst_n = 1'b0;
    logic       rxd, txd;
    logic       cfg_mp = 0, cfg_len8 = 1, cfg_par_en = 0, cfg_par_odd = 0;
    logic       tx_enable = 0, rx_enable = 0, tx_irq_en = 0, rx_irq_en = 0;
    logic       tx_wr = 0, tx_wad = 0, rx_rd = 0;
    logic [7:0] tx_wdata = '0;
    logic       tx_empty, rx_ad, rx_full, err_frame, err_parity, err_overrun, tx_irq, rx_irq;
    logic [7:0] rx_rdata;
    logic       loop = 0, rx_drv = 1;

    assign rxd = loop ? txd : rx_drv;

    mp_uart #(.DIV(DIV)) u_mp_uart (
        .clk(clk), .rst_n(rst_n), .rxd(rxd), .txd(txd),
        .cfg_mp(cfg_mp), .cfg_len8(cfg_len8), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
        .tx_enable(tx_enable), .rx_enable(rx_enable), .tx_irq_en(tx_irq_en), .rx_irq_en(rx_irq_en),
        .tx_wr(tx_wr), .tx_wdata(tx_wdata), .tx_wad(tx_wad), .tx_empty(tx_empty),
        .rx_rd(rx_rd), .rx_rdata(rx_rdata), .rx_ad(rx_ad), .rx_full(rx_full),
        .err_frame(err_frame), .err_parity(err_parity), .err_overrun(err_overrun),
        .tx_irq(tx_irq), .rx_irq(rx_irq)
    );

    int n_tests = 0;
    int n_fail  = 0;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    function automatic int dlen_of(input logic mp, input logic l8);
        return (mp || l8) ? 8 : 7;
    endfunction

    // expected line bits, index 0 = start bit
    function automatic logic [10:0] build(input logic [7:0] dv, input logic adv, input logic mp,
                                          input logic l8, input logic pe, input logic odd);
        logic [10:0] f;
        int dl;
        int ones;
        f    = '1;
        f[0] = 1'b0;
        dl   = dlen_of(mp, l8);
        ones = 0;
        for (int i = 0; i < dl; i++) begin
            f[1 + i] = dv[i];
            ones += int'(dv[i]);
        end
        if (mp)      f[1 + dl] = adv;
        else if (pe) f[1 + dl] = ((ones % 2) == 1) ^ odd;
        return f;
    endfunction

    function automatic int nbits(input logic mp, input logic pe, input logic l8);
        return 2 + dlen_of(mp, l8) + ((mp || pe) ? 1 : 0);
    endfunction

    task automatic write_tx(input logic [7:0] dv, input logic adv);
        @(negedge clk);
        tx_wdata = dv; tx_wad = adv; tx_wr = 1'b1;
        @(negedge clk);
        tx_wr = 1'b0;
    endtask

    task automatic read_rx();
        @(negedge clk);
        rx_rd = 1'b1;
        @(negedge clk);
        rx_rd = 1'b0;
    endtask

    task automatic capture_tx(input int n, output logic [10:0] got);
        int t;
        got = '1;
        t = 0;
        while (txd !== 1'b0 && t < 4 * BITC) begin
            @(negedge clk);
            t++;
        end
        // R6: empty returns with the start edge
        check("R6 empty at start bit", tx_empty, 1'b1);
        repeat (BITC / 2) @(negedge clk);
        got[0] = txd;
        for (int k = 1; k < n; k++) begin
            repeat (BITC) @(negedge clk);
            got[k] = txd;
        end
    endtask

    task automatic send_raw(input logic [10:0] f, input int n, input int last_len);
        @(negedge clk);
        for (int k = 0; k < n; k++) begin
            rx_drv = f[k];
            repeat ((k == n - 1) ? last_len : BITC) @(negedge clk);
        end
        rx_drv = 1'b1;
        repeat (BITC) @(negedge clk);
    endtask

    initial begin
        logic [10:0] got, exp_f;
        logic [7:0]  dv;
        logic        adv;
        int          n;
        string       tag;

        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1
        check("R1 txd idle", txd, 1'b1);
        check("R1 tx_empty", tx_empty, 1'b1);
        check("R1 rx_full", rx_full, 1'b0);
        check("R1 errors", {err_frame, err_parity, err_overrun}, 3'b000);
        // R13
        check("R13 irqs off when disabled", {tx_irq, rx_irq}, 2'b00);

        // loopback sweep over every configuration
        tx_irq_en = 1; rx_irq_en = 1;
        loop = 1; tx_enable = 1; rx_enable = 1;
        for (int cfg = 0; cfg < 16; cfg++) begin
            for (int v = 0; v < 2; v++) begin
                @(negedge clk);
                cfg_mp = cfg[3]; cfg_len8 = cfg[2]; cfg_par_en = cfg[1]; cfg_par_odd = cfg[0];
                dv  = (v == 1) ? (8'h5A ^ 8'(cfg * 17)) : (8'hC3 + 8'(cfg));
                adv = dv[0] ^ v[0];
                tag = cfg_mp ? "R5" : (cfg_par_en ? "R4" : (cfg_len8 ? "R2" : "R3"));
                n     = nbits(cfg_mp, cfg_par_en, cfg_len8);
                exp_f = build(dv, adv, cfg_mp, cfg_len8, cfg_par_en, cfg_par_odd);
                write_tx(dv, adv);
                check("R6 write clears empty", tx_empty, 1'b0);
                check("R13 tx_irq low when full", tx_irq, 1'b0);
                capture_tx(n, got);
                check({tag, " tx frame"}, got, exp_f);
                repeat (BITC) @(negedge clk);
                check("R9 rx_full set", rx_full, 1'b1);
                check("R13 rx_irq", rx_irq, 1'b1);
                check({tag, " rx data"}, rx_rdata, (dlen_of(cfg_mp, cfg_len8) == 8) ? dv : {1'b0, dv[6:0]});
                check("R4 no parity error", err_parity, 1'b0);
                check("R10 no framing error", err_frame, 1'b0);
                check("R5 rx ad bit", rx_ad, cfg_mp ? adv : 1'b0);
                read_rx();
                check("R9 read clears full", rx_full, 1'b0);
            end
        end

        // directed receive tests: 8 data bits, even parity
        loop = 0;
        @(negedge clk);
        cfg_mp = 0; cfg_len8 = 1; cfg_par_en = 1; cfg_par_odd = 0;
        // R4: bad parity (data 01 needs parity 1)
        send_raw({1'b1, 1'b0, 8'h01, 1'b0}, 11, BITC);
        check("R4 parity error", err_parity, 1'b1);
        check("R4 data kept", rx_rdata, 8'h01);
        check("R10 no frame error on bad parity", err_frame, 1'b0);
        read_rx();
        check("R9 read clears errors", {err_parity, err_frame, err_overrun}, 3'b000);
        // R10: low stop bit, held low just past its centre
        send_raw({1'b0, 1'b1, 8'h01, 1'b0}, 11, BITC / 2 + 8);
        check("R10 framing error", err_frame, 1'b1);
        check("R10 parity ok", err_parity, 1'b0);
        read_rx();
        check("R9 read clears frame error", err_frame, 1'b0);
        check("R12 no spurious frame after low stop", rx_full, 1'b0);
        // R11: overrun
        rx_irq_en = 0;
        send_raw({1'b1, 1'b0, 8'h33, 1'b0}, 11, BITC);
        check("R13 rx_irq masked", rx_irq, 1'b0);
        send_raw({1'b1, 1'b0, 8'h44, 1'b0}, 11, BITC);
        check("R11 overrun flag", err_overrun, 1'b1);
        check("R11 data kept", rx_rdata, 8'h33);
        check("R11 still full", rx_full, 1'b1);
        read_rx();
        check("R9 read clears overrun", {rx_full, err_overrun}, 2'b00);
        // R12: false start
        @(negedge clk);
        rx_drv = 1'b0;
        repeat (4 * DIV) @(negedge clk);
        rx_drv = 1'b1;
        repeat (2 * BITC) @(negedge clk);
        check("R12 false start dropped", rx_full, 1'b0);
        send_raw({1'b1, 1'b0, 8'h96, 1'b0}, 11, BITC);
        check("R12 next frame received", rx_rdata, 8'h96);
        check("R12 next frame full", rx_full, 1'b1);
        read_rx();
        // R8: receiver disabled
        rx_enable = 0;
        send_raw({1'b1, 1'b0, 8'h5C, 1'b0}, 11, BITC);
        check("R8 disabled receiver ignores frame", rx_full, 1'b0);
        rx_enable = 1;

        // R7 / R6: transmitter held off, second write ignored
        cfg_par_en = 0;
        tx_enable  = 0;
        write_tx(8'h11, 1'b0);
        repeat (3 * BITC) @(negedge clk);
        check("R7 txd idle while disabled", txd, 1'b1);
        check("R7 byte held", tx_empty, 1'b0);
        write_tx(8'h22, 1'b0);
        @(negedge clk);
        tx_enable = 1;
        capture_tx(10, got);
        check("R6 write while full ignored", got, build(8'h11, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0));
        repeat (BITC) @(negedge clk);
        tx_irq_en = 0;
        @(negedge clk);
        check("R13 tx_irq masked", tx_irq, 1'b0);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule